// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirector

This block takes a software interrupt vector raised while the processor runs in virtual-8086 mode and decides how it is delivered. When the virtual-mode extension is enabled, the block looks up one bit per vector in a redirection bitmap. The bitmap sits just below the I/O permission map inside the task-state segment. If the vector's bit is clear, the interrupt is handled the way a real-mode processor would: a three-word frame is pushed, the handler address is fetched from the low-memory interrupt table, and the caller is told which trap and interrupt flags to clear. In every other case the block reports either a general-protection fault or that normal protected-mode delivery should go ahead.

The surrounding core pulses `start` with the vector and a snapshot of the relevant state. That state is the low half of the flags register, the virtual interrupt flag, the task-register base and limit, and the current code selector and instruction pointer. The block then uses one system-memory read port, which serves both word and byte reads, and one 16-bit stack push port. Both ports use a request/acknowledge handshake. The outcome is returned with a single-cycle `done` strobe.

Top module: `vint_redirect`

## Requirements
- R1: If the extension is disabled at `start`, the block issues no read and no push. It returns fault (`result`=3) when the IOPL field `eflags_lo[13:12]` is below 3, and otherwise returns deliver (`result`=2).
- R2: If the extension is enabled and `tr_limit` is below 103, the block returns fault with no memory access. A limit of exactly 103 allows the lookup to proceed.
- R3: The first read is a word at `tr_base`+102, which holds the I/O map base B. The bitmap byte offset is B − 32 + (vector >> 3), computed as an unsigned 32-bit value that wraps. If this offset is greater than `tr_limit`, the result is fault and no further read is made.
- R4: The bitmap byte is read at `tr_base`+offset and arrives in `rd_data[7:0]`. If bit (vector & 7) of that byte is set, the vector is not redirected. The result is then fault when IOPL < 3 and deliver when IOPL = 3.
- R5: If the bit is clear, the block reads the word at vector×4+2 as the new CS and then the word at vector×4 as the new IP. Both are returned on `new_cs`/`new_ip` with result redirect (`result`=1).
- R6: The pushed flags word equals `eflags_lo` when IOPL = 3. When IOPL < 3, bits 13:12 are forced to 11 and bit 9 (IF) is replaced by `vif`.
- R7: A redirect performs exactly three 16-bit pushes, in the order flags, old CS, old IP. Each push is held until `push_ack`.
- R8: With a redirect result, `clr_trap` (clear TF and RF) is high. In the same cycle `clr_if` is high if IOPL = 3 and `clr_vif` is high otherwise. All three are low with any other result.
- R9: `done` is high for exactly one cycle per request. `result` (1 redirect, 2 deliver, 3 fault) holds until the next `done`. A `start` that arrives while a request is in progress is ignored.
- R10: `rd_word` is 1 for the I/O base and table reads and 0 for the bitmap byte. `rd_req` and `rd_addr` stay steady until `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| vector | input | 8 | Software interrupt vector |
| vme_en | input | 1 | Virtual-mode extension enable |
| eflags_lo | input | 16 | Low half of the flags register (IOPL in 13:12) |
| vif | input | 1 | Current virtual interrupt flag |
| tr_base | input | 32 | Task-state segment base |
| tr_limit | input | 32 | Task-state segment limit |
| cur_cs | input | 16 | Code selector at the interrupt |
| cur_ip | input | 16 | Return instruction pointer |
| rd_req | output | 1 | System read request |
| rd_addr | output | 32 | System read address |
| rd_word | output | 1 | 1 word read, 0 byte read |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 16 | Read data (byte in bits 7:0) |
| push_req | output | 1 | Stack push request |
| push_data | output | 16 | Word to push |
| push_ack | input | 1 | Push accepted |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 1 redirect, 2 deliver, 3 fault |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 16 | Handler instruction pointer |
| clr_trap | output | 1 | Clear TF and RF |
| clr_if | output | 1 | Clear IF |
| clr_vif | output | 1 | Clear VIF |

## Verification
The responders acknowledge on the falling edge that follows each request, with no wait states. Under that condition `done` is due a fixed number of rising edges after the edge that samples `start`. It is due after 1 edge for an early decision (extension off, or short limit), after 2 for an out-of-range bitmap offset, after 3 for a set bitmap bit, and after 8 for a full redirect. The bench counts rising edges from the start edge and reads `done` and the other outputs on the falling edge after each one. It compares the count against the value expected for the path it predicted. Then, on the next falling edge, it confirms that `done` has dropped while `result` still holds.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  localparam int unsigned VRD_AW      = 32;
  localparam int unsigned IOB_OFS     = 102;
  localparam int unsigned TSS_MIN_LIM = 103;
  localparam int unsigned BMP_BELOW   = 32;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_REDIR   = 2'd1,
    RES_DELIVER = 2'd2,
    RES_FAULT   = 2'd3
  } vrd_res_e;

  typedef enum logic [1:0] {
    RK_IOBASE = 2'd0,
    RK_BITMAP = 2'd1,
    RK_IVT_CS = 2'd2,
    RK_IVT_IP = 2'd3
  } vrd_rdkind_e;

  // byte offset of the redirection bitmap byte, unsigned wrap
  function automatic logic [VRD_AW-1:0] bmp_offset(input logic [15:0] io_base,
                                                   input logic [7:0] vec);
    return VRD_AW'(io_base) - VRD_AW'(BMP_BELOW) + VRD_AW'(vec[7:3]);
  endfunction

  // flags image pushed on a redirect
  function automatic logic [15:0] forge_flags(input logic [15:0] f, input logic vif);
    logic [15:0] r;
    r = f;
    if (f[13:12] != 2'b11) begin
      r[13:12] = 2'b11;
      r[9]     = vif;
    end
    return r;
  endfunction

  // low-memory table entry address: hi selects the selector word
  function automatic logic [VRD_AW-1:0] ivt_addr(input logic [7:0] vec, input logic hi);
    return VRD_AW'({vec, hi, 1'b0});
  endfunction
endpackage

// File: rtl/vrd_lookup.sv
module vrd_lookup
  import vrd_pkg::*;
#(
  parameter int unsigned AW = VRD_AW
) (
  input  vrd_rdkind_e   kind,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic [7:0]    vec,
  output logic [AW-1:0] addr,
  output logic          word
);
  always_comb begin
    unique case (kind)
      RK_IOBASE: begin addr = base + AW'(IOB_OFS); word = 1'b1; end
      RK_BITMAP: begin addr = base + offset;       word = 1'b0; end
      RK_IVT_CS: begin addr = AW'(ivt_addr(vec, 1'b1)); word = 1'b1; end
      default:   begin addr = AW'(ivt_addr(vec, 1'b0)); word = 1'b1; end
    endcase
  end
endmodule

// File: rtl/vrd_frame.sv
module vrd_frame
  import vrd_pkg::*;
(
  input  logic [15:0] flags,
  input  logic        vif,
  input  logic [15:0] ret_cs,
  input  logic [15:0] ret_ip,
  input  logic [1:0]  sel,
  output logic [15:0] data
);
  logic [15:0] forged;
  assign forged = forge_flags(flags, vif);

  always_comb begin
    unique case (sel)
      2'd0:    data = forged;
      2'd1:    data = ret_cs;
      default: data = ret_ip;
    endcase
  end
endmodule

// File: rtl/vrd_ctrl.sv
module vrd_ctrl
  import vrd_pkg::*;
#(
  parameter int unsigned AW      = VRD_AW,
  parameter int unsigned MIN_LIM = TSS_MIN_LIM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    vector,
  input  logic          vme_en,
  input  logic [15:0]   eflags_lo,
  input  logic          vif,
  input  logic [AW-1:0] tr_base,
  input  logic [AW-1:0] tr_limit,
  input  logic [15:0]   cur_cs,
  input  logic [15:0]   cur_ip,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  input  logic          push_ack,
  output logic          rd_req,
  output vrd_rdkind_e   rd_kind,
  output logic          push_req,
  output logic [1:0]    push_sel,
  output logic [7:0]    vec_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] off_q,
  output logic [15:0]   flags_q,
  output logic          vif_q,
  output logic [15:0]   cs_q,
  output logic [15:0]   ip_q,
  output logic          done,
  output logic [1:0]    result,
  output logic [15:0]   new_cs,
  output logic [15:0]   new_ip,
  output logic          clr_trap,
  output logic          clr_if,
  output logic          clr_vif
);
  typedef enum logic [2:0] {S_IDLE, S_IOB, S_BMP, S_CS, S_IP, S_PF, S_PC, S_PI} st_e;

  st_e           st, st_nx;
  logic [AW-1:0] lim_q, off_nx;
  logic          done_q, redir_q;
  vrd_res_e      res_q, fin_res;
  logic          fin;
  logic          iopl_low;
  // named internal events
  logic          ev_limit_fault, ev_range_fault, ev_bitmap_hit, ev_redirect_go;

  assign iopl_low = (flags_q[13:12] != 2'b11);
  assign off_nx   = AW'(bmp_offset(rd_data, vec_q));

  always_comb begin
    st_nx = st; fin = 1'b0; fin_res = RES_NONE;
    ev_limit_fault = 1'b0; ev_range_fault = 1'b0;
    ev_bitmap_hit  = 1'b0; ev_redirect_go = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        if (!vme_en) begin
          fin = 1'b1;
          fin_res = (eflags_lo[13:12] != 2'b11) ? RES_FAULT : RES_DELIVER;
        end else if (tr_limit < AW'(MIN_LIM)) begin
          fin = 1'b1; fin_res = RES_FAULT; ev_limit_fault = 1'b1;
        end else st_nx = S_IOB;
      end
      S_IOB: if (rd_ack) begin
        if (off_nx > lim_q) begin
          fin = 1'b1; fin_res = RES_FAULT; ev_range_fault = 1'b1;
        end else st_nx = S_BMP;
      end
      S_BMP: if (rd_ack) begin
        if (rd_data[vec_q[2:0]]) begin
          ev_bitmap_hit = 1'b1; fin = 1'b1;
          fin_res = iopl_low ? RES_FAULT : RES_DELIVER;
        end else begin
          ev_redirect_go = 1'b1; st_nx = S_CS;
        end
      end
      S_CS: if (rd_ack) st_nx = S_IP;
      S_IP: if (rd_ack) st_nx = S_PF;
      S_PF: if (push_ack) st_nx = S_PC;
      S_PC: if (push_ack) st_nx = S_PI;
      default: if (push_ack) begin fin = 1'b1; fin_res = RES_REDIR; end
    endcase
    if (fin) st_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done_q <= 1'b0; res_q <= RES_NONE; redir_q <= 1'b0;
      vec_q <= '0; base_q <= '0; lim_q <= '0; off_q <= '0;
      flags_q <= '0; vif_q <= 1'b0; cs_q <= '0; ip_q <= '0;
      new_cs <= '0; new_ip <= '0;
    end else begin
      st     <= st_nx;
      done_q <= fin;
      if (fin) res_q <= fin_res;
      if (st == S_IDLE && start) begin
        vec_q <= vector; base_q <= tr_base; lim_q <= tr_limit;
        flags_q <= eflags_lo; vif_q <= vif; cs_q <= cur_cs; ip_q <= cur_ip;
        redir_q <= 1'b0;
      end
      if (st == S_IOB && rd_ack) off_q <= off_nx;
      if (ev_redirect_go) redir_q <= 1'b1;
      if (st == S_CS && rd_ack) new_cs <= rd_data;
      if (st == S_IP && rd_ack) new_ip <= rd_data;
    end
  end

  always_comb begin
    rd_req   = (st == S_IOB) || (st == S_BMP) || (st == S_CS) || (st == S_IP);
    push_req = (st == S_PF) || (st == S_PC) || (st == S_PI);
    unique case (st)
      S_BMP:   rd_kind = RK_BITMAP;
      S_CS:    rd_kind = RK_IVT_CS;
      S_IP:    rd_kind = RK_IVT_IP;
      default: rd_kind = RK_IOBASE;
    endcase
    unique case (st)
      S_PC:    push_sel = 2'd1;
      S_PI:    push_sel = 2'd2;
      default: push_sel = 2'd0;
    endcase
  end

  assign done     = done_q;
  assign result   = res_q;
  assign clr_trap = done_q && (res_q == RES_REDIR);
  assign clr_if   = clr_trap && !iopl_low;
  assign clr_vif  = clr_trap && iopl_low;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd0));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!rd_req && !push_req));
  assert_push_needs_clear_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> redir_q);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_kind)));
  assert_push_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_ack) |=> (push_req && $stable(push_sel)));
  assert_clr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_if && clr_vif));
  assert_limit_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_limit_fault |=> (!rd_req && done));
endmodule

// File: rtl/vint_redirect.sv
module vint_redirect
  import vrd_pkg::*;
#(
  parameter int unsigned AW      = VRD_AW,
  parameter int unsigned MIN_LIM = TSS_MIN_LIM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    vector,
  input  logic          vme_en,
  input  logic [15:0]   eflags_lo,
  input  logic          vif,
  input  logic [AW-1:0] tr_base,
  input  logic [AW-1:0] tr_limit,
  input  logic [15:0]   cur_cs,
  input  logic [15:0]   cur_ip,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_word,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  output logic          push_req,
  output logic [15:0]   push_data,
  input  logic          push_ack,
  output logic          done,
  output logic [1:0]    result,
  output logic [15:0]   new_cs,
  output logic [15:0]   new_ip,
  output logic          clr_trap,
  output logic          clr_if,
  output logic          clr_vif
);
  vrd_rdkind_e   rd_kind;
  logic [1:0]    push_sel;
  logic [7:0]    vec_q;
  logic [AW-1:0] base_q, off_q;
  logic [15:0]   flags_q, cs_q, ip_q;
  logic          vif_q;

  vrd_ctrl #(.AW(AW), .MIN_LIM(MIN_LIM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .vme_en(vme_en),
    .eflags_lo(eflags_lo), .vif(vif), .tr_base(tr_base), .tr_limit(tr_limit),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .rd_ack(rd_ack), .rd_data(rd_data),
    .push_ack(push_ack), .rd_req(rd_req), .rd_kind(rd_kind), .push_req(push_req),
    .push_sel(push_sel), .vec_q(vec_q), .base_q(base_q), .off_q(off_q),
    .flags_q(flags_q), .vif_q(vif_q), .cs_q(cs_q), .ip_q(ip_q), .done(done),
    .result(result), .new_cs(new_cs), .new_ip(new_ip), .clr_trap(clr_trap),
    .clr_if(clr_if), .clr_vif(clr_vif)
  );

  vrd_lookup #(.AW(AW)) u_lookup (
    .kind(rd_kind), .base(base_q), .offset(off_q), .vec(vec_q),
    .addr(rd_addr), .word(rd_word)
  );

  vrd_frame u_frame (
    .flags(flags_q), .vif(vif_q), .ret_cs(cs_q), .ret_ip(ip_q),
    .sel(push_sel), .data(push_data)
  );

  assert_forged_iopl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_sel == 2'd0 && flags_q[13:12] != 2'b11)
      |-> (push_data[13:12] == 2'b11 && push_data[9] == vif_q));
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));
endmodule

// File: tb/sim_vint_redirect.sv
`timescale 1ns/1ps
module sim_vint_redirect;
  localparam logic [31:0] TSS = 32'h0010_0000;
  localparam logic [1:0] E_REDIR = 2'd1, E_DELIV = 2'd2, E_FAULT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, vme_en = 1'b0, vif = 1'b0;
  logic [7:0] vector = '0;
  logic [15:0] eflags_lo = '0, cur_cs = '0, cur_ip = '0;
  logic [31:0] tr_base = TSS, tr_limit = 32'h0FFF;
  logic rd_req, rd_word, rd_ack = 1'b0, push_req, push_ack = 1'b0;
  logic [31:0] rd_addr;
  logic [15:0] rd_data = '0, push_data, new_cs, new_ip;
  logic done, clr_trap, clr_if, clr_vif;
  logic [1:0] result;
  logic [15:0] io_val = 16'h0088;

  integer n_chk = 0, n_fail = 0, cyc = 0, rcnt = 0, pcnt = 0, werr = 0;
  logic [31:0] rlog [16];
  logic [15:0] plog [16];

  always #2 clk = ~clk;

  vint_redirect u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .vme_en(vme_en),
    .eflags_lo(eflags_lo), .vif(vif), .tr_base(tr_base), .tr_limit(tr_limit),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_ack(rd_ack), .rd_data(rd_data), .push_req(push_req),
    .push_data(push_data), .push_ack(push_ack), .done(done), .result(result),
    .new_cs(new_cs), .new_ip(new_ip), .clr_trap(clr_trap), .clr_if(clr_if),
    .clr_vif(clr_vif)
  );

  function automatic logic [15:0] ivt_word(input logic [31:0] a);
    return a[15:0] * 16'd29 + 16'h0B0B;
  endfunction
  function automatic logic [7:0] bm_byte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ 8'h6B;
  endfunction

  // zero-wait responders, driven on the falling edge
  always @(negedge clk) begin
    rd_ack   <= rd_req;
    push_ack <= push_req;
    if (rd_req) begin
      if (rd_addr == TSS + 32'd102) rd_data <= io_val;
      else if (rd_addr >= TSS)      rd_data <= {8'h00, bm_byte(rd_addr)};
      else                          rd_data <= ivt_word(rd_addr);
      if (rd_word != ((rd_addr < TSS) || (rd_addr == TSS + 32'd102))) werr = werr + 1;
      rlog[rcnt % 16] = rd_addr;
      rcnt = rcnt + 1;
    end
    if (push_req) begin
      plog[pcnt % 16] = push_data;
      pcnt = pcnt + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] v, input logic vme, input logic [1:0] iop,
                     input logic vi, input logic [31:0] lim, input logic [15:0] iob,
                     input logic poke);
    logic [15:0] ef, ocs, oip, fexp;
    logic [31:0] off;
    logic [7:0]  bb;
    logic [1:0]  er;
    integer el, nr, lat, rb, pb, wb;
    string tg;
    ef  = ((16'h8A55 ^ {v, v}) & ~16'h3000) | (16'(iop) << 12);
    ocs = 16'hF000 ^ {8'h00, v};
    oip = 16'h1234 + {8'h00, v};
    off = {16'h0, iob} - 32'd32 + {27'h0, v[7:3]};
    bb  = bm_byte(TSS + off);
    if (!vme) begin er = (iop != 2'd3) ? E_FAULT : E_DELIV; el = 1; nr = 0; tg = "R1"; end
    else if (lim < 32'd103) begin er = E_FAULT; el = 1; nr = 0; tg = "R2"; end
    else if (off > lim) begin er = E_FAULT; el = 2; nr = 1; tg = "R3"; end
    else if (bb[v[2:0]]) begin er = (iop != 2'd3) ? E_FAULT : E_DELIV; el = 3; nr = 2; tg = "R4"; end
    else begin er = E_REDIR; el = 8; nr = 4; tg = "R5"; end
    fexp = ef;
    if (iop != 2'd3) begin fexp[13:12] = 2'b11; fexp[9] = vi; end

    io_val = iob; vector = v; vme_en = vme; eflags_lo = ef; vif = vi;
    tr_limit = lim; cur_cs = ocs; cur_ip = oip; start = 1'b1;
    rb = rcnt; pb = pcnt; wb = werr; lat = 0;
    while (lat < 40) begin
      @(posedge clk); lat = lat + 1;
      @(negedge clk);
      if (lat == 1) start = 1'b0;
      if (poke && lat == 3) begin start = 1'b1; vector = ~v; end
      if (poke && lat == 4) start = 1'b0;
      if (done) break;
    end
    chk(done, "R9 done seen", 32'(done), 1);
    chk(result == er, tg, 32'(result), 32'(er));
    chk(lat == el, "R9 latency", lat, el);
    chk((rcnt - rb) == nr, "R10 read count", rcnt - rb, nr);
    chk(werr == wb, "R10 read width", werr - wb, 0);
    if (nr >= 1) chk(rlog[rb % 16] == TSS + 32'd102, "R3 iobase addr", rlog[rb % 16], TSS + 32'd102);
    if (nr >= 2) chk(rlog[(rb + 1) % 16] == TSS + off, "R4 bitmap addr", rlog[(rb + 1) % 16], TSS + off);
    if (nr == 4) begin
      chk(rlog[(rb + 2) % 16] == {22'h0, v, 2'b10}, "R5 cs addr", rlog[(rb + 2) % 16], {22'h0, v, 2'b10});
      chk(rlog[(rb + 3) % 16] == {22'h0, v, 2'b00}, "R5 ip addr", rlog[(rb + 3) % 16], {22'h0, v, 2'b00});
      chk(new_cs == ivt_word({22'h0, v, 2'b10}), "R5 new_cs", new_cs, ivt_word({22'h0, v, 2'b10}));
      chk(new_ip == ivt_word({22'h0, v, 2'b00}), "R5 new_ip", new_ip, ivt_word({22'h0, v, 2'b00}));
      chk((pcnt - pb) == 3, "R7 push count", pcnt - pb, 3);
      chk(plog[pb % 16] == fexp, "R6 flags image", plog[pb % 16], fexp);
      chk(plog[(pb + 1) % 16] == ocs, "R7 push cs", plog[(pb + 1) % 16], ocs);
      chk(plog[(pb + 2) % 16] == oip, "R7 push ip", plog[(pb + 2) % 16], oip);
    end else begin
      chk((pcnt - pb) == 0, "R7 no push", pcnt - pb, 0);
    end
    chk(clr_trap == (er == E_REDIR), "R8 clr_trap", 32'(clr_trap), 32'(er == E_REDIR));
    chk(clr_if == (er == E_REDIR && iop == 2'd3), "R8 clr_if", 32'(clr_if), 32'(er == E_REDIR && iop == 2'd3));
    chk(clr_vif == (er == E_REDIR && iop != 2'd3), "R8 clr_vif", 32'(clr_vif), 32'(er == E_REDIR && iop != 2'd3));
    @(posedge clk); @(negedge clk);
    chk(!done, "R9 single pulse", 32'(done), 0);
    chk(result == er, "R9 result held", 32'(result), 32'(er));
  endtask

  initial begin
    logic [7:0] pv;
    logic [7:0] tb_b;
    repeat (3) @(negedge clk);
    chk(!done && !rd_req && !push_req && result == 2'd0, "R9 reset state",
        {done, rd_req, push_req, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // extension off, every IOPL value
    for (int i = 0; i < 4; i++) run(8'h21, 1'b0, 2'(i), 1'b1, 32'h0FFF, 16'h0088, 1'b0);
    // limit boundary around 103
    run(8'h00, 1'b1, 2'd3, 1'b0, 32'd102, 16'h0080, 1'b0);
    run(8'h00, 1'b1, 2'd3, 1'b0, 32'd103, 16'h0080, 1'b0);
    run(8'h00, 1'b1, 2'd0, 1'b1, 32'd103, 16'h0080, 1'b0);
    // bitmap offset at and past the limit: 0x88-32+8 = 112
    run(8'h40, 1'b1, 2'd3, 1'b0, 32'd112, 16'h0088, 1'b0);
    run(8'h40, 1'b1, 2'd0, 1'b0, 32'd111, 16'h0088, 1'b0);
    // I/O base below 32 wraps the offset
    run(8'h00, 1'b1, 2'd3, 1'b0, 32'h0FFF, 16'h0010, 1'b0);

    // sweep: every vector, IOPL 0 and 3, VIF 0 and 1
    for (int v = 0; v < 256; v++)
      for (int k = 0; k < 4; k++)
        run(8'(v), 1'b1, (k[1]) ? 2'd3 : 2'd0, k[0], 32'h0FFF, 16'h0088, 1'b0);

    // start while busy is ignored (R9): find a redirected vector
    pv = 8'h00;
    for (int v = 255; v >= 0; v--) begin
      tb_b = bm_byte(TSS + 32'h68 + 32'(v >> 3));
      if (!tb_b[v % 8]) pv = 8'(v);
    end
    run(pv, 1'b1, 2'd1, 1'b1, 32'h0FFF, 16'h0088, 1'b1);

    summary();
    $finish;
  end
endmodule